// File: doc/BRIEF.md
# I2C Master Bus Clock and Data Timing Generator

This block produces the SCL waveform for an I2C master and marks, with single-cycle ticks, the points where the byte engine may change SDA, where a slave-side setup window opens, and where SDA should be sampled. All timing is counted in system clock cycles. Six count inputs, a low count and a high count for each of three speed modes, set the phase lengths. A 2-bit speed selector picks the pair in use. Each count gets a fixed offset added, and a floor is applied first.

A 16-bit hold value places the SDA change point a fixed distance after SCL falls. The change point is limited so that SDA always settles before SCL rises again. An 8-bit setup value places a tick ahead of the SCL rise. A master does not use this tick, but it is provided for slave logic. While SCL is released, a slave that holds the line low pauses the high-phase count. The sample tick sits at the middle of the high phase. Raising `run` starts the clock with a low phase. Dropping it releases SCL on the next cycle.

Top module: `i2c_scl_timer`

## Requirements
- R1: With `run` high, each SCL low phase (`scl_out` = 0) lasts max(low count, 8) + 1 cycles.
- R2: With no stretching, each SCL high phase (`scl_out` = 1) lasts max(high count, 6) + 8 cycles.
- R3: `speed` selects the count pair: 1 standard (`std_hi`/`std_lo`), 2 fast (`fst_hi`/`fst_lo`), 3 high (`hs_hi`/`hs_lo`). The value 0 is treated as standard.
- R4: `sda_tick` pulses once per low phase, at low-phase cycle index hold + 2. Index 0 is the first cycle with `scl_out` = 0.
- R5: When hold + 2 would exceed low length - 2, `sda_tick` comes at index low length - 2, which is still before SCL rises.
- R6: `setup_tick` pulses once per low phase, at index L - 1 - d. Here L is the low length and d = setup - 1, with setup 0 taken as 1. If d is at least L, the tick comes at index 0.
- R7: While `scl_in` is low during a high phase, the high count pauses. The high phase grows by exactly the number of stretched cycles.
- R8: `sample_tick` pulses once per high phase, at counted index floor(high length / 2), and only while `scl_in` is high.
- R9: When `run` is low, `scl_out` is 1 on the next cycle and no ticks follow. When `run` rises, SCL goes low on the next cycle.
- R10: Out of reset, `scl_out` is 1 and all ticks are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Enables SCL generation |
| speed | input | 2 | Speed mode select (0/1 standard, 2 fast, 3 high) |
| std_hi | input | 16 | Standard-mode high count |
| std_lo | input | 16 | Standard-mode low count |
| fst_hi | input | 16 | Fast-mode high count |
| fst_lo | input | 16 | Fast-mode low count |
| hs_hi | input | 16 | High-speed-mode high count |
| hs_lo | input | 16 | High-speed-mode low count |
| hold_val | input | 16 | SDA hold value |
| setup_val | input | 8 | SDA setup value |
| scl_in | input | 1 | Sensed SCL line level |
| scl_out | output | 1 | SCL drive: 0 pulls low, 1 releases |
| sda_tick | output | 1 | SDA change point |
| setup_tick | output | 1 | Setup window point |
| sample_tick | output | 1 | SDA sample point |

## Verification
Each speed value is run with count pairs that differ, so a wrong selector decode shows up as a wrong phase length. Both pairs sit at or below their floors, so a missing clamp or a wrong offset gives a distinct length. Hold and setup values are chosen to land inside the low phase, at its last usable cycle, and far past it, which separates the plain offset from the two limits. A slave stretch injected mid-high-phase must lengthen that phase by exactly its own duration. Stopping and restarting `run` checks the release and the low-first start.

// File: rtl/i2c_scl_timer_pkg.sv
package i2c_scl_timer_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_e;

    localparam int unsigned LOW_FLOOR  = 8;
    localparam int unsigned HIGH_FLOOR = 6;
    localparam int unsigned LOW_ADD    = 1;
    localparam int unsigned HIGH_ADD   = 8;
    localparam int unsigned HOLD_ADD   = 2;
endpackage

// File: rtl/scl_phase_len.sv
module scl_phase_len
    import i2c_scl_timer_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int LEN_W = CNT_W + 2
) (
    input  logic [1:0]       speed,
    input  logic [CNT_W-1:0] std_hi,
    input  logic [CNT_W-1:0] std_lo,
    input  logic [CNT_W-1:0] fst_hi,
    input  logic [CNT_W-1:0] fst_lo,
    input  logic [CNT_W-1:0] hs_hi,
    input  logic [CNT_W-1:0] hs_lo,
    output logic [LEN_W-1:0] lo_len,
    output logic [LEN_W-1:0] hi_len
);
    logic [CNT_W-1:0] lo_raw, hi_raw;
    logic [LEN_W-1:0] lo_ext, hi_ext;

    // speed 0 falls back to the standard pair
    always_comb begin
        unique case (speed)
            2'd2:    begin lo_raw = fst_lo; hi_raw = fst_hi; end
            2'd3:    begin lo_raw = hs_lo;  hi_raw = hs_hi;  end
            default: begin lo_raw = std_lo; hi_raw = std_hi; end
        endcase
    end

    always_comb begin
        lo_ext = LEN_W'(lo_raw);
        hi_ext = LEN_W'(hi_raw);
        if (lo_ext < LEN_W'(LOW_FLOOR))  lo_ext = LEN_W'(LOW_FLOOR);
        if (hi_ext < LEN_W'(HIGH_FLOOR)) hi_ext = LEN_W'(HIGH_FLOOR);
        lo_len = lo_ext + LEN_W'(LOW_ADD);
        hi_len = hi_ext + LEN_W'(HIGH_ADD);
    end
endmodule

// File: rtl/scl_tick_points.sv
module scl_tick_points
    import i2c_scl_timer_pkg::*;
#(
    parameter int LEN_W  = 18,
    parameter int HOLD_W = 16,
    parameter int SET_W  = 8
) (
    input  logic [LEN_W-1:0]  lo_len,
    input  logic [LEN_W-1:0]  hi_len,
    input  logic [HOLD_W-1:0] hold_val,
    input  logic [SET_W-1:0]  setup_val,
    output logic [LEN_W-1:0]  sda_idx,
    output logic [LEN_W-1:0]  setup_idx,
    output logic [LEN_W-1:0]  smp_idx
);
    logic [LEN_W-1:0] hold_pos, hold_lim, set_dist;

    always_comb begin
        // change point kept at least one cycle ahead of the last low cycle
        hold_pos = LEN_W'(hold_val) + LEN_W'(HOLD_ADD);
        hold_lim = lo_len - LEN_W'(2);
        sda_idx  = (hold_pos > hold_lim) ? hold_lim : hold_pos;

        set_dist  = (setup_val == '0) ? '0 : LEN_W'(setup_val) - LEN_W'(1);
        setup_idx = (set_dist >= lo_len) ? '0 : lo_len - LEN_W'(1) - set_dist;

        smp_idx = hi_len >> 1;
    end
endmodule

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer
    import i2c_scl_timer_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int HOLD_W = 16,
    parameter int SET_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [1:0]        speed,
    input  logic [CNT_W-1:0]  std_hi,
    input  logic [CNT_W-1:0]  std_lo,
    input  logic [CNT_W-1:0]  fst_hi,
    input  logic [CNT_W-1:0]  fst_lo,
    input  logic [CNT_W-1:0]  hs_hi,
    input  logic [CNT_W-1:0]  hs_lo,
    input  logic [HOLD_W-1:0] hold_val,
    input  logic [SET_W-1:0]  setup_val,
    input  logic              scl_in,
    output logic              scl_out,
    output logic              sda_tick,
    output logic              setup_tick,
    output logic              sample_tick
);
    localparam int LEN_W = ((CNT_W > HOLD_W) ? CNT_W : HOLD_W) + 2;

    typedef struct packed {
        phase_e           ph;
        logic [LEN_W-1:0] cnt;
    } tmr_state_t;

    tmr_state_t       r_d, r_q;
    logic [LEN_W-1:0] lo_len, hi_len, sda_idx, setup_idx, smp_idx;

    scl_phase_len #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_len (
        .speed (speed),
        .std_hi(std_hi), .std_lo(std_lo),
        .fst_hi(fst_hi), .fst_lo(fst_lo),
        .hs_hi (hs_hi),  .hs_lo (hs_lo),
        .lo_len(lo_len), .hi_len(hi_len)
    );

    scl_tick_points #(.LEN_W(LEN_W), .HOLD_W(HOLD_W), .SET_W(SET_W)) u_pts (
        .lo_len   (lo_len),
        .hi_len   (hi_len),
        .hold_val (hold_val),
        .setup_val(setup_val),
        .sda_idx  (sda_idx),
        .setup_idx(setup_idx),
        .smp_idx  (smp_idx)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.ph)
            PH_IDLE: begin
                if (run) begin
                    r_d.ph  = PH_LOW;
                    r_d.cnt = '0;
                end
            end
            PH_LOW: begin
                if (!run) begin
                    r_d.ph  = PH_IDLE;
                    r_d.cnt = '0;
                end else if (r_q.cnt >= lo_len - LEN_W'(1)) begin
                    r_d.ph  = PH_HIGH;
                    r_d.cnt = '0;
                end else begin
                    r_d.cnt = r_q.cnt + LEN_W'(1);
                end
            end
            PH_HIGH: begin
                if (!run) begin
                    r_d.ph  = PH_IDLE;
                    r_d.cnt = '0;
                end else if (scl_in) begin
                    // counting only while the line is seen high
                    if (r_q.cnt >= hi_len - LEN_W'(1)) begin
                        r_d.ph  = PH_LOW;
                        r_d.cnt = '0;
                    end else begin
                        r_d.cnt = r_q.cnt + LEN_W'(1);
                    end
                end
            end
            default: begin
                r_d.ph  = PH_IDLE;
                r_d.cnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.ph  <= PH_IDLE;
            r_q.cnt <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign scl_out     = (r_q.ph != PH_LOW);
    assign sda_tick    = (r_q.ph == PH_LOW)  && (r_q.cnt == sda_idx);
    assign setup_tick  = (r_q.ph == PH_LOW)  && (r_q.cnt == setup_idx);
    assign sample_tick = (r_q.ph == PH_HIGH) && scl_in && (r_q.cnt == smp_idx);

    assert_low_ends_on_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ph == PH_LOW && run && r_q.cnt < lo_len - LEN_W'(1)) |=> (r_q.ph == PH_LOW));

    assert_stretch_pauses_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ph == PH_HIGH && run && !scl_in) |=> (r_q.ph == PH_HIGH && $stable(r_q.cnt)));

    assert_sda_tick_in_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sda_tick |-> !scl_out);

    assert_sample_when_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sample_tick |-> (scl_out && scl_in));

    assert_stop_releases_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (scl_out && !sda_tick && !setup_tick && !sample_tick));
endmodule

// File: tb/tb_i2c_scl_timer.sv
module tb_i2c_scl_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic [1:0]  speed = 2'd1;
    logic [15:0] std_hi = 16'd10, std_lo = 16'd20;
    logic [15:0] fst_hi = 16'd2,  fst_lo = 16'd3;
    logic [15:0] hs_hi  = 16'd7,  hs_lo  = 16'd9;
    logic [15:0] hold_val = 16'd3;
    logic [7:0]  setup_val = 8'd4;
    logic        pull = 1'b0;
    logic        scl_in;
    logic        scl_out, sda_tick, setup_tick, sample_tick;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    assign scl_in = scl_out & ~pull;

    always #10 clk = ~clk;

    i2c_scl_timer dut (
        .clk(clk), .rst_n(rst_n), .run(run), .speed(speed),
        .std_hi(std_hi), .std_lo(std_lo), .fst_hi(fst_hi), .fst_lo(fst_lo),
        .hs_hi(hs_hi), .hs_lo(hs_lo), .hold_val(hold_val), .setup_val(setup_val),
        .scl_in(scl_in), .scl_out(scl_out), .sda_tick(sda_tick),
        .setup_tick(setup_tick), .sample_tick(sample_tick)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual cycle %0d expected below 100000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Measures one full low phase followed by one high phase
    task automatic measure(input bit stretch, output int lo_n, output int hi_n,
                           output int sda_i, output int set_i, output int smp_i,
                           output int n_sda, output int n_smp);
        int g;
        lo_n = 0; hi_n = 0; sda_i = -1; set_i = -1; smp_i = -1; n_sda = 0; n_smp = 0;
        g = 0;
        @(negedge clk);
        while (!scl_out && g < 3000) begin @(negedge clk); g++; end
        while (scl_out && g < 3000) begin @(negedge clk); g++; end
        while (!scl_out && g < 3000) begin
            if (sda_tick) begin if (sda_i < 0) sda_i = lo_n; n_sda++; end
            if (setup_tick && set_i < 0) set_i = lo_n;
            lo_n++; g++;
            @(negedge clk);
        end
        while (scl_out && g < 3000) begin
            if (stretch && hi_n == 3) pull = 1'b1;
            if (stretch && hi_n == 8) pull = 1'b0;
            if (sample_tick) begin if (smp_i < 0) smp_i = hi_n; n_smp++; end
            hi_n++; g++;
            @(negedge clk);
        end
        pull = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R10 scl released in reset", int'(scl_out), 1);
        chk("R10 ticks quiet in reset", int'({sda_tick, setup_tick, sample_tick}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 scl released after reset", int'(scl_out), 1);
    endtask

    task automatic t_standard();
        int lo, hi, si, ui, mi, ns, nm;
        speed = 2'd1; hold_val = 16'd3; setup_val = 8'd4;
        run = 1'b1;
        measure(1'b0, lo, hi, si, ui, mi, ns, nm);
        chk("R1 standard low length", lo, 21);
        chk("R2 standard high length", hi, 18);
        chk("R4 sda tick index", si, 5);
        chk("R4 sda tick once", ns, 1);
        chk("R6 setup tick index", ui, 17);
        chk("R8 sample tick index", mi, 9);
        chk("R8 sample tick once", nm, 1);
    endtask

    task automatic t_fast_clamp();
        int lo, hi, si, ui, mi, ns, nm;
        speed = 2'd2; hold_val = 16'd0; setup_val = 8'd1;
        measure(1'b0, lo, hi, si, ui, mi, ns, nm);
        chk("R1 fast low floor", lo, 9);
        chk("R2 fast high floor", hi, 14);
        chk("R4 sda tick hold zero", si, 2);
        chk("R6 setup tick last low cycle", ui, 8);
        chk("R8 fast sample index", mi, 7);
    endtask

    task automatic t_high_speed();
        int lo, hi, si, ui, mi, ns, nm;
        speed = 2'd3; hold_val = 16'd1; setup_val = 8'd0;
        measure(1'b0, lo, hi, si, ui, mi, ns, nm);
        chk("R3 high-speed low length", lo, 10);
        chk("R3 high-speed high length", hi, 15);
        chk("R4 sda tick high speed", si, 3);
        chk("R6 setup zero as one", ui, 9);
    endtask

    task automatic t_speed_zero();
        int lo, hi, si, ui, mi, ns, nm;
        speed = 2'd0; hold_val = 16'd3; setup_val = 8'd4;
        measure(1'b0, lo, hi, si, ui, mi, ns, nm);
        chk("R3 speed 0 low as standard", lo, 21);
        chk("R3 speed 0 high as standard", hi, 18);
    endtask

    task automatic t_hold_limit();
        int lo, hi, si, ui, mi, ns, nm;
        speed = 2'd1; hold_val = 16'd100;
        measure(1'b0, lo, hi, si, ui, mi, ns, nm);
        chk("R5 hold limited to low-2", si, 19);
        hold_val = 16'd17;
        measure(1'b0, lo, hi, si, ui, mi, ns, nm);
        chk("R5 hold exactly at limit", si, 19);
        hold_val = 16'd16;
        measure(1'b0, lo, hi, si, ui, mi, ns, nm);
        chk("R4 hold just below limit", si, 18);
        hold_val = 16'd3;
    endtask

    task automatic t_setup_far();
        int lo, hi, si, ui, mi, ns, nm;
        speed = 2'd1; setup_val = 8'd50;
        measure(1'b0, lo, hi, si, ui, mi, ns, nm);
        chk("R6 setup beyond low phase", ui, 0);
        setup_val = 8'd4;
    endtask

    task automatic t_stretch();
        int lo, hi, si, ui, mi, ns, nm;
        speed = 2'd1;
        measure(1'b1, lo, hi, si, ui, mi, ns, nm);
        chk("R7 stretched high length", hi, 23);
        chk("R8 sample once under stretch", nm, 1);
        measure(1'b0, lo, hi, si, ui, mi, ns, nm);
        chk("R7 following low unaffected", lo, 21);
    endtask

    task automatic t_run_stop();
        int lo, hi, si, ui, mi, ns, nm;
        @(negedge clk);
        while (scl_out) @(negedge clk);
        run = 1'b0;
        @(negedge clk);
        chk("R9 stop releases scl", int'(scl_out), 1);
        for (int i = 0; i < 30; i++) begin
            if (!scl_out || sda_tick || setup_tick || sample_tick) begin
                chk("R9 idle stays quiet", 1, 0);
                break;
            end
            @(negedge clk);
        end
        run = 1'b1;
        @(negedge clk);
        chk("R9 restart begins low", int'(scl_out), 0);
        measure(1'b0, lo, hi, si, ui, mi, ns, nm);
        chk("R9 restart low length", lo, 21);
    endtask

    initial begin
        t_reset();
        t_standard();
        t_fast_clamp();
        t_high_speed();
        t_speed_zero();
        t_hold_limit();
        t_setup_far();
        t_stretch();
        t_run_stop();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule